// File: doc/BRIEF.md
# External Interrupt Flag and Mask Unit

This block collects eight external interrupt pins for a small processor core. Each pin first passes through a synchroniser. A per-line sense setting then decides what counts as an event on that line: a low level, any change, a falling edge or a rising edge. An edge or change event latches a status bit in the flag register. A level setting does not latch anything. Its request follows the synchronised pin while the pin stays low.

Software reads and writes the mask and flag registers through a simple single-cycle port. Writing a one to a flag bit clears it. When the core takes the vector for a line, it reports that line on the acknowledge input, and this also clears the flag. A line asks for service when the global enable, its mask bit and its condition are all true. When several lines ask at once, the lowest-numbered one is presented as the pending line. A pin driven by its own port logic still counts as an input, so software can raise a request by toggling that pin.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset, the mask register and the flag register both read as zero.
- R2: A write with `reg_sel_i`=0 loads the mask register. Reading with `reg_sel_i`=0 returns the mask, and reading with `reg_sel_i`=1 returns the flags. Bit n belongs to line n.
- R3: Sense code for line n is `sense_cfg_i[2n+1:2n]`: 2'b01 means any change, 2'b10 means falling edge and 2'b11 means rising edge. A matching pin transition first sampled at clock edge k sets flag n after edge k+2. A non-matching transition leaves the flag at zero.
- R4: A write with `reg_sel_i`=1 clears each flag bit whose data bit is one. Flag bits whose data bit is zero keep their value.
- R5: A cycle with `ack_valid_i`=1 clears the flag of the line given by `ack_line_i` and leaves the other flags unchanged.
- R6: Sense code 2'b00 selects low level. Under this code the line's flag reads zero one cycle later and stays zero. The line's condition is true while the synchronised pin is low, and it changes after edge k+1 for a pin change first sampled at edge k.
- R7: `irq_valid_o` is zero whenever `gie_i` is zero, and it is also zero when no line with a set mask bit has a true condition.
- R8: When `gie_i` is one, `irq_valid_o` is one if any masked-in line has a true condition, and `irq_line_o` then gives the lowest-numbered such line.
- R9: If a flag set and a clear (by write-one or by acknowledge) fall on the same bit in the same cycle, the flag ends up set.
- R10: Idle pin levels present through reset do not set any flag once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Raw external interrupt pins, asynchronous |
| sense_cfg_i | input | 16 | Two sense bits per line, line n at bits 2n+1:2n |
| gie_i | input | 1 | Global interrupt enable from the core |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 = mask, 1 = flags |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the selected register |
| ack_valid_i | input | 1 | Vector taken by the core |
| ack_line_i | input | 3 | Line whose vector was taken |
| irq_valid_o | output | 1 | A request is pending for the core |
| irq_line_o | output | 3 | Lowest-numbered pending line |

## Verification
A flag's hardware set can fall in the same clock edge as a clear, and the clear can come from a write-one or from a vector acknowledge. The bench sets up each collision in turn. It toggles a pin in any-change mode that already has its flag set, and it times the write or the acknowledge so that it is sampled at the same edge where the new event latches. The flag is then read back and must still be one, and a control case shows that the same clear on its own does clear the bit. Priority is checked by sweeping all 256 mask values with every flag set and comparing the reported line with the lowest set bit of the mask.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_ANY  = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_RISE = 2'b11
   } sense_e;

   localparam int SENSE_W = 2;

   localparam logic SEL_MASK = 1'b0;
   localparam logic SEL_FLAG = 1'b1;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
   parameter int NUM_LINES   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] pin_i,
   output logic [NUM_LINES-1:0] sync_o,
   output logic [NUM_LINES-1:0] prev_o,
   output logic                 primed_o
);

   localparam int PRIME_CNT = SYNC_STAGES + 1;
   localparam int CNT_W     = $clog2(PRIME_CNT + 1);

   logic [NUM_LINES-1:0] stage_q [SYNC_STAGES];
   logic [NUM_LINES-1:0] prev_q;
   logic [CNT_W-1:0]     prime_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q[0] <= '0;
      end else begin
         stage_q[0] <= pin_i;
      end
   end

   for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[s] <= '0;
         end else begin
            stage_q[s] <= stage_q[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         prime_q <= '0;
      end else begin
         prev_q <= stage_q[SYNC_STAGES-1];
         if (prime_q != CNT_W'(PRIME_CNT)) begin
            prime_q <= prime_q + CNT_W'(1);
         end
      end
   end

   assign sync_o   = stage_q[SYNC_STAGES-1];
   assign prev_o   = prev_q;
   assign primed_o = (prime_q == CNT_W'(PRIME_CNT));

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
   import ext_irq_pkg::*;
#(
   parameter int NUM_LINES = 8
) (
   input  logic [NUM_LINES*SENSE_W-1:0] sense_cfg_i,
   input  logic [NUM_LINES-1:0]         sync_i,
   input  logic [NUM_LINES-1:0]         prev_i,
   input  logic                         primed_i,
   output logic [NUM_LINES-1:0]         edge_evt_o,
   output logic [NUM_LINES-1:0]         level_act_o,
   output logic [NUM_LINES-1:0]         is_level_o
);

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      sense_e mode;
      assign mode = sense_e'(sense_cfg_i[i*SENSE_W +: SENSE_W]);

      always_comb begin
         edge_evt_o[i]  = 1'b0;
         level_act_o[i] = 1'b0;
         is_level_o[i]  = 1'b0;
         unique case (mode)
            SENSE_LOW: begin
               is_level_o[i]  = 1'b1;
               level_act_o[i] = primed_i & ~sync_i[i];
            end
            SENSE_ANY:  edge_evt_o[i] = primed_i & (sync_i[i] ^ prev_i[i]);
            SENSE_FALL: edge_evt_o[i] = primed_i & prev_i[i] & ~sync_i[i];
            SENSE_RISE: edge_evt_o[i] = primed_i & ~prev_i[i] & sync_i[i];
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
   import ext_irq_pkg::*;
#(
   parameter int NUM_LINES = 8,
   parameter int IDX_W     = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr_i,
   input  logic                 reg_sel_i,
   input  logic [NUM_LINES-1:0] reg_wdata_i,
   input  logic                 ack_valid_i,
   input  logic [IDX_W-1:0]     ack_line_i,
   input  logic [NUM_LINES-1:0] edge_evt_i,
   input  logic [NUM_LINES-1:0] is_level_i,
   output logic [NUM_LINES-1:0] mask_o,
   output logic [NUM_LINES-1:0] flag_o,
   output logic [NUM_LINES-1:0] clr_o,
   output logic [NUM_LINES-1:0] rdata_o
);

   logic [NUM_LINES-1:0] mask_q;
   logic [NUM_LINES-1:0] flag_q;
   logic [NUM_LINES-1:0] flag_d;
   logic                 flag_wr;

   assign flag_wr = reg_wr_i & (reg_sel_i == SEL_FLAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (reg_wr_i && reg_sel_i == SEL_MASK) begin
         mask_q <= reg_wdata_i;
      end
   end

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_flag
      assign clr_o[i] = (flag_wr & reg_wdata_i[i])
                      | (ack_valid_i & (ack_line_i == IDX_W'(i)));

      always_comb begin
         if (is_level_i[i]) begin
            flag_d[i] = 1'b0;
         end else if (edge_evt_i[i]) begin
            flag_d[i] = 1'b1;
         end else if (clr_o[i]) begin
            flag_d[i] = 1'b0;
         end else begin
            flag_d[i] = flag_q[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
      end else begin
         flag_q <= flag_d;
      end
   end

   assign mask_o  = mask_q;
   assign flag_o  = flag_q;
   assign rdata_o = (reg_sel_i == SEL_FLAG) ? flag_q : mask_q;

endmodule

// File: rtl/ext_irq_prio.sv
module ext_irq_prio #(
   parameter int NUM_LINES = 8,
   parameter int IDX_W     = 3
) (
   input  logic [NUM_LINES-1:0] req_i,
   output logic                 valid_o,
   output logic [IDX_W-1:0]     idx_o
);

   always_comb begin
      idx_o = '0;
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            idx_o = IDX_W'(i);
         end
      end
   end

   assign valid_o = |req_i;

endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
   import ext_irq_pkg::*;
#(
   parameter int NUM_LINES   = 8,
   parameter int SYNC_STAGES = 2,
   parameter int IDX_W       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_LINES-1:0]         pin_i,
   input  logic [NUM_LINES*SENSE_W-1:0] sense_cfg_i,
   input  logic                         gie_i,
   input  logic                         reg_wr_i,
   input  logic                         reg_sel_i,
   input  logic [NUM_LINES-1:0]         reg_wdata_i,
   output logic [NUM_LINES-1:0]         reg_rdata_o,
   input  logic                         ack_valid_i,
   input  logic [IDX_W-1:0]             ack_line_i,
   output logic                         irq_valid_o,
   output logic [IDX_W-1:0]             irq_line_o
);

   if (NUM_LINES < 1) begin : g_bad_lines
      $error("ext_irq_unit: NUM_LINES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ext_irq_unit: SYNC_STAGES must be at least 2");
   end
   if ((1 << IDX_W) < NUM_LINES) begin : g_bad_idx
      $error("ext_irq_unit: IDX_W too narrow for NUM_LINES");
   end

   logic [NUM_LINES-1:0] sync_v;
   logic [NUM_LINES-1:0] prev_v;
   logic                 primed;
   logic [NUM_LINES-1:0] edge_evt;
   logic [NUM_LINES-1:0] level_act;
   logic [NUM_LINES-1:0] is_level;
   logic [NUM_LINES-1:0] mask_q;
   logic [NUM_LINES-1:0] flag_q;
   logic [NUM_LINES-1:0] clr_vec;
   logic [NUM_LINES-1:0] req_vec;

   ext_irq_sync #(
      .NUM_LINES   (NUM_LINES),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_i    (pin_i),
      .sync_o   (sync_v),
      .prev_o   (prev_v),
      .primed_o (primed)
   );

   ext_irq_detect #(
      .NUM_LINES (NUM_LINES)
   ) u_detect (
      .sense_cfg_i (sense_cfg_i),
      .sync_i      (sync_v),
      .prev_i      (prev_v),
      .primed_i    (primed),
      .edge_evt_o  (edge_evt),
      .level_act_o (level_act),
      .is_level_o  (is_level)
   );

   ext_irq_regs #(
      .NUM_LINES (NUM_LINES),
      .IDX_W     (IDX_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr_i    (reg_wr_i),
      .reg_sel_i   (reg_sel_i),
      .reg_wdata_i (reg_wdata_i),
      .ack_valid_i (ack_valid_i),
      .ack_line_i  (ack_line_i),
      .edge_evt_i  (edge_evt),
      .is_level_i  (is_level),
      .mask_o      (mask_q),
      .flag_o      (flag_q),
      .clr_o       (clr_vec),
      .rdata_o     (reg_rdata_o)
   );

   assign req_vec = gie_i ? ((flag_q | level_act) & mask_q) : '0;

   ext_irq_prio #(
      .NUM_LINES (NUM_LINES),
      .IDX_W     (IDX_W)
   ) u_prio (
      .req_i   (req_vec),
      .valid_o (irq_valid_o),
      .idx_o   (irq_line_o)
   );

endmodule

// File: rtl/ext_irq_checker.sv
module ext_irq_checker #(
   parameter int NUM_LINES = 8,
   parameter int IDX_W     = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 gie_i,
   input logic                 irq_valid_o,
   input logic [IDX_W-1:0]     irq_line_o,
   input logic [NUM_LINES-1:0] mask_q,
   input logic [NUM_LINES-1:0] flag_q,
   input logic [NUM_LINES-1:0] level_act,
   input logic [NUM_LINES-1:0] is_level,
   input logic [NUM_LINES-1:0] edge_evt,
   input logic [NUM_LINES-1:0] clr_vec
);

   logic [NUM_LINES-1:0] cand;
   logic [NUM_LINES-1:0] below;

   assign cand  = (flag_q | level_act) & mask_q;
   assign below = (NUM_LINES'(1) << irq_line_o) - NUM_LINES'(1);

   p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_i |-> !irq_valid_o);

   p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cand == '0) |-> !irq_valid_o);

   p_pick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid_o |-> (cand[irq_line_o] && ((cand & below) == '0)));

   p_serve_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (gie_i && cand != '0) |-> irq_valid_o);

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      p_level_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
         is_level[i] |=> !flag_q[i]);

      p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_evt[i] && !is_level[i]) |=> flag_q[i]);

      p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_vec[i] && !edge_evt[i]) |=> !flag_q[i]);

      p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_vec[i] && !edge_evt[i] && !is_level[i]) |=> $stable(flag_q[i]));
   end

endmodule

bind ext_irq_unit ext_irq_checker #(
   .NUM_LINES (NUM_LINES),
   .IDX_W     (IDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .gie_i       (gie_i),
   .irq_valid_o (irq_valid_o),
   .irq_line_o  (irq_line_o),
   .mask_q      (mask_q),
   .flag_q      (flag_q),
   .level_act   (level_act),
   .is_level    (is_level),
   .edge_evt    (edge_evt),
   .clr_vec     (clr_vec)
);

// File: tb/test_ext_irq_unit.sv
module test_ext_irq_unit;

   localparam int CLK_PERIOD = 10;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [N-1:0] pin;
   logic [15:0]  cfg;
   logic         gie;
   logic         reg_wr;
   logic         reg_sel;
   logic [N-1:0] wdata;
   logic [N-1:0] rdata;
   logic         ack_valid;
   logic [2:0]   ack_line;
   logic         irq_valid;
   logic [2:0]   irq_line;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ext_irq_unit i_ext_irq_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_i       (pin),
      .sense_cfg_i (cfg),
      .gie_i       (gie),
      .reg_wr_i    (reg_wr),
      .reg_sel_i   (reg_sel),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata),
      .ack_valid_i (ack_valid),
      .ack_line_i  (ack_line),
      .irq_valid_o (irq_valid),
      .irq_line_o  (irq_line)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [N-1:0] d);
      reg_wr = 1'b1; reg_sel = sel; wdata = d;
      tick(1);
      reg_wr = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic sel, output logic [N-1:0] d);
      reg_sel = sel;
      #1;
      d = rdata;
   endtask

   task automatic ack(input int line);
      ack_valid = 1'b1; ack_line = 3'(line);
      tick(1);
      ack_valid = 1'b0;
   endtask

   function automatic logic [15:0] all_mode(input logic [1:0] m);
      return {8{m}};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] d;
      rst_n = 1'b0; pin = '1; cfg = all_mode(2'b11); gie = 1'b0;
      reg_wr = 1'b0; reg_sel = 1'b0; wdata = '0; ack_valid = 1'b0; ack_line = '0;
      tick(3);
      rst_n = 1'b1;
      tick(6);

      // R1 / R10: reset values, idle-high pins in rising mode set nothing
      rd(1'b0, d); check("R1 mask", d, 0);
      rd(1'b1, d); check("R10 flags after reset", d, 0);

      // R2: mask write and readback
      wr(1'b0, 8'hA5);
      rd(1'b0, d); check("R2 mask A5", d, 8'hA5);
      rd(1'b1, d); check("R2 flag select", d, 0);
      wr(1'b0, 8'h00);
      rd(1'b0, d); check("R2 mask 00", d, 0);

      // R3: sweep line x mode x direction
      for (int ln = 0; ln < N; ln++) begin
         for (int m = 1; m < 4; m++) begin
            for (int dir = 0; dir < 2; dir++) begin
               bit hit;
               cfg = all_mode(2'(m));
               pin[ln] = (dir == 1) ? 1'b0 : 1'b1;
               tick(4);
               wr(1'b1, 8'hFF);
               tick(1);
               pin[ln] = (dir == 1) ? 1'b1 : 1'b0;
               tick(3);
               hit = (m == 1) || (m == 3 && dir == 1) || (m == 2 && dir == 0);
               rd(1'b1, d);
               check($sformatf("R3 line %0d mode %0d dir %0d", ln, m, dir),
                     d, hit ? (1 << ln) : 0);
               pin[ln] = 1'b1;
               tick(4);
               wr(1'b1, 8'hFF);
               tick(1);
            end
         end
      end

      // R3: latency, any-change on line 2
      cfg = all_mode(2'b01);
      pin[2] = 1'b0;
      tick(2);
      rd(1'b1, d); check("R3 not yet after 2 edges", d, 0);
      tick(1);
      rd(1'b1, d); check("R3 set after 3 edges", d, 8'h04);
      wr(1'b1, 8'hFF);
      pin[2] = 1'b1; tick(4); wr(1'b1, 8'hFF); tick(1);

      // R4: write-one-to-clear
      pin[1] = 1'b0; pin[3] = 1'b0;
      tick(4);
      rd(1'b1, d); check("R4 two flags", d, 8'h0A);
      wr(1'b1, 8'h00);
      rd(1'b1, d); check("R4 zero write keeps", d, 8'h0A);
      wr(1'b1, 8'h02);
      rd(1'b1, d); check("R4 clear bit1", d, 8'h08);
      wr(1'b1, 8'h08);
      rd(1'b1, d); check("R4 clear bit3", d, 8'h00);

      // R5: acknowledge clears one line
      pin[1] = 1'b1; pin[3] = 1'b1;
      tick(4);
      rd(1'b1, d); check("R5 two flags", d, 8'h0A);
      ack(3);
      rd(1'b1, d); check("R5 ack line 3", d, 8'h02);
      ack(1);
      rd(1'b1, d); check("R5 ack line 1", d, 8'h00);

      // R7: gating by global enable and mask
      pin[5] = 1'b0;
      tick(4);
      wr(1'b0, 8'hFF); gie = 1'b0; #1;
      check("R7 gie off", irq_valid, 0);
      gie = 1'b1; wr(1'b0, 8'h00); #1;
      check("R7 mask off", irq_valid, 0);
      wr(1'b0, 8'h20); #1;
      check("R7 enabled valid", irq_valid, 1);
      check("R8 line 5", irq_line, 5);
      wr(1'b1, 8'hFF);
      pin[5] = 1'b1; tick(4); wr(1'b1, 8'hFF); tick(1);

      // R8: all flags set, sweep every mask
      pin = '0;
      tick(4);
      rd(1'b1, d); check("R8 all flags", d, 8'hFF);
      for (int m = 0; m < 256; m++) begin
         int low;
         low = 0;
         for (int b = 7; b >= 0; b--) if (m[b]) low = b;
         wr(1'b0, 8'(m)); #1;
         check($sformatf("R8 valid mask %0h", m), irq_valid, (m != 0) ? 1 : 0);
         if (m != 0) check($sformatf("R8 line mask %0h", m), irq_line, low);
      end
      gie = 1'b0; #1;
      check("R7 gie off with all pending", irq_valid, 0);
      gie = 1'b1;
      pin = '1; tick(4); wr(1'b1, 8'hFF); wr(1'b0, 8'h00); tick(1);

      // R6: level sensing on line 4
      pin[4] = 1'b0; tick(4);
      rd(1'b1, d); check("R6 edge flag before switch", d, 8'h10);
      cfg[9:8] = 2'b00;
      tick(1);
      rd(1'b1, d); check("R6 level clears flag", d, 8'h00);
      wr(1'b0, 8'h10); #1;
      check("R6 low pin requests", irq_valid, 1);
      check("R6 line 4", irq_line, 4);
      pin[4] = 1'b1;
      tick(1); #1;
      check("R6 one edge later still low", irq_valid, 1);
      tick(1); #1;
      check("R6 released after two edges", irq_valid, 0);
      pin[4] = 1'b0;
      tick(2); #1;
      check("R6 low again", irq_valid, 1);
      rd(1'b1, d); check("R6 flag stays zero", d, 8'h00);
      pin[4] = 1'b1; tick(3);
      cfg = all_mode(2'b01); wr(1'b0, 8'h00); tick(1);

      // R9: set wins against write-one-to-clear
      pin[0] = 1'b0; tick(4);
      rd(1'b1, d); check("R9 flag set", d, 8'h01);
      pin[0] = 1'b1;
      tick(2);
      wr(1'b1, 8'h01);
      rd(1'b1, d); check("R9 set beats write clear", d, 8'h01);
      wr(1'b1, 8'h01);
      rd(1'b1, d); check("R4 plain write clears", d, 8'h00);
      pin[0] = 1'b0; tick(4);
      pin[0] = 1'b1;
      tick(2);
      ack(0);
      rd(1'b1, d); check("R9 set beats ack", d, 8'h01);
      ack(0);
      rd(1'b1, d); check("R5 plain ack clears", d, 8'h00);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule